// File: doc/BRIEF.md
# Mitigation Option Control Register with Core Aggregation

This block holds one 64-bit mitigation option register for every hardware thread of a core, together with a small aggregator that merges the threads' options into core-wide enables. Software writes a thread's register through a single write port that selects the thread, and reads any thread's register back through a read port. A write is checked before it lands. If it sets a reserved bit, or a bit whose capability strap is low, the write is refused with a fault flag and no register changes.

Two sticky locks restrict the options. Both are set by single-cycle pulses from the update-load logic and apply to every thread of the core. Only reset clears them. The transaction lock pins the transaction-allow option at zero. The gather-sampling lock pins the gather-sampling disable option at zero. Per-thread outputs give the random-number mitigation state, the abort-every-transaction condition and the buffer-clear skip. The gather-sampling mitigation is disabled at core level only when every thread asks for it, and that decision is registered.

Top module: `mitopt_core`

Register fields, by bit position: 0 random-number mitigation disable, 1 transaction allow, 2 transaction lock (read-only), 3 fill-buffer clear skip, 4 gather-sampling mitigation disable, 5 gather-sampling lock (read-only), 63:6 reserved.

## Requirements
- R1: After reset every thread register reads 0, gds_mitig_on is 1 and wr_fault is 0.
- R2: An accepted write to thread wr_tid stores write-data bits 0, 1, 3 and 4 into that thread only, and a read of that thread then returns them. Written values of bits 2 and 5 are ignored and raise no fault.
- R3: A write with any of bits 63:6 set raises wr_fault in the same cycle, and the register keeps its previous value.
- R4: A write that sets bit 0 while cap_rng_ctl is 0, bit 3 while cap_fbclr_ctl is 0, or bit 4 while cap_gds_ctl is 0 raises wr_fault and leaves the register unchanged. Writing 0 to those bits is accepted.
- R5: rng_mitig_on[t] is 0 only when bit 0 of thread t is 1 and in_enclave[t] is 0; otherwise it is 1.
- R6: txn_abort_all[t] is 1 when bit 1 of thread t is 0; when bit 1 is 1 it equals txn_disable[t].
- R7: A pulse on lock_rtm_set sets bit 2 on all threads and clears bit 1. From then on writes to bit 1 are ignored without a fault, while the other bits of the same write are stored.
- R8: A pulse on lock_gds_set sets bit 5 on all threads and forces bit 4 to 0, and this also applies to a write in the same cycle. From then on a read returns bit 4 as 0 whatever is written.
- R9: Bits 2 and 5 stay set through any writes and are cleared only by reset.
- R10: gds_mitig_on is 0 exactly when bit 4 was 1 on every thread in the previous cycle. It changes one clock after the last thread's bit 4 changes.
- R11: fbclr_skip[t] equals bit 3 of thread t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_rng_ctl | input | 1 | Strap: bit 0 implemented |
| cap_fbclr_ctl | input | 1 | Strap: bit 3 implemented |
| cap_gds_ctl | input | 1 | Strap: bit 4 implemented |
| wr_en | input | 1 | Write request |
| wr_tid | input | TIDW | Thread selected for the write |
| wr_data | input | REG_W | Write data |
| wr_fault | output | 1 | Current write refused (same cycle) |
| rd_tid | input | TIDW | Thread selected for the read |
| rd_data | output | REG_W | Register of the read thread |
| lock_rtm_set | input | 1 | Pulse: set the transaction lock |
| lock_gds_set | input | 1 | Pulse: set the gather-sampling lock |
| in_enclave | input | NTHR | Thread is executing inside a secure enclave |
| txn_disable | input | NTHR | Separate per-thread transaction-disable control |
| rng_mitig_on | output | NTHR | Random-number mitigation active per thread |
| txn_abort_all | output | NTHR | Every transaction-begin aborts with code 0 |
| fbclr_skip | output | NTHR | Buffer-clear instruction skips fill-buffer overwrite |
| gds_mitig_on | output | 1 | Core-level gather-sampling mitigation active |

## Verification
A software write and a lock pulse can land in the same cycle. The result of that race is defined: the lock wins over the written value of the bit it guards. The bench provokes this by raising lock_gds_set in the cycle of a write that sets bit 4. It then checks that the readback shows bit 5 set and bit 4 clear, that the other thread's bit 4 was also cleared, and that gds_mitig_on returns to 1 one clock later. A second case pulses the transaction lock and then writes bit 1 together with other bits, judging that only bit 1 is dropped and no fault is raised.

// File: rtl/mitopt_pkg.sv
package mitopt_pkg;

    localparam int unsigned OPT_W      = 64;
    localparam int unsigned B_RNG_DIS  = 0;
    localparam int unsigned B_TXN_ALW  = 1;
    localparam int unsigned B_RTM_LCK  = 2;
    localparam int unsigned B_FB_SKIP  = 3;
    localparam int unsigned B_GDS_DIS  = 4;
    localparam int unsigned B_GDS_LCK  = 5;
    localparam int unsigned RSV_LO     = 6;

    typedef struct packed {
        logic gds_lock;
        logic gds_dis;
        logic fb_skip;
        logic rtm_lock;
        logic txn_allow;
        logic rng_dis;
    } opt_t;

    function automatic logic [OPT_W-1:0] opt_to_word(opt_t o);
        logic [OPT_W-1:0] w;
        w            = '0;
        w[B_RNG_DIS] = o.rng_dis;
        w[B_TXN_ALW] = o.txn_allow;
        w[B_RTM_LCK] = o.rtm_lock;
        w[B_FB_SKIP] = o.fb_skip;
        w[B_GDS_DIS] = o.gds_dis;
        w[B_GDS_LCK] = o.gds_lock;
        return w;
    endfunction

endpackage

// File: rtl/mitopt_wr_check.sv
module mitopt_wr_check
    import mitopt_pkg::*;
#(
    parameter int unsigned REG_W = OPT_W
) (
    input  logic [REG_W-1:0] wr_data,
    input  logic             cap_rng_ctl,
    input  logic             cap_fbclr_ctl,
    input  logic             cap_gds_ctl,
    output logic             illegal
);
    localparam int unsigned RSV_W = REG_W - RSV_LO;

    logic rsv_hit;
    logic cap_hit;

    always_comb begin
        rsv_hit = |wr_data[REG_W-1:RSV_LO];
        cap_hit = (wr_data[B_RNG_DIS] & ~cap_rng_ctl)
                | (wr_data[B_FB_SKIP] & ~cap_fbclr_ctl)
                | (wr_data[B_GDS_DIS] & ~cap_gds_ctl);
        illegal = rsv_hit | cap_hit;
    end

    initial begin
        assert (RSV_W > 0) else $error("register narrower than field map");
    end

endmodule

// File: rtl/mitopt_thread_reg.sv
module mitopt_thread_reg
    import mitopt_pkg::*;
#(
    parameter int unsigned REG_W = OPT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ok,
    input  logic [REG_W-1:0] wr_data,
    input  logic             lock_rtm_set,
    input  logic             lock_gds_set,
    input  logic             in_enclave,
    input  logic             txn_disable,
    output logic [REG_W-1:0] word,
    output logic             gds_dis,
    output logic             rng_mitig_on,
    output logic             txn_abort_all,
    output logic             fbclr_skip
);
    opt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lock_rtm_set) st_d.rtm_lock = 1'b1;
        if (lock_gds_set) st_d.gds_lock = 1'b1;
        if (wr_ok) begin
            st_d.rng_dis   = wr_data[B_RNG_DIS];
            st_d.fb_skip   = wr_data[B_FB_SKIP];
            st_d.txn_allow = wr_data[B_TXN_ALW];
            st_d.gds_dis   = wr_data[B_GDS_DIS];
        end
        // locks win over any same-cycle write
        if (st_d.rtm_lock) st_d.txn_allow = 1'b0;
        if (st_d.gds_lock) st_d.gds_dis   = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        word          = REG_W'(opt_to_word(st_q));
        gds_dis       = st_q.gds_dis;
        rng_mitig_on  = ~(st_q.rng_dis & ~in_enclave);
        txn_abort_all = st_q.txn_allow ? txn_disable : 1'b1;
        fbclr_skip    = st_q.fb_skip;
    end

    p_rtm_lock_pins_allow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rtm_lock |-> !st_q.txn_allow);
    p_gds_lock_pins_dis_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_gds_set |=> (st_q.gds_lock && !st_q.gds_dis));
    p_locks_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.gds_lock || st_q.rtm_lock) |=>
        (st_q.gds_lock >= $past(st_q.gds_lock)) && (st_q.rtm_lock >= $past(st_q.rtm_lock)));
    p_idle_no_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ok && !lock_rtm_set && !lock_gds_set) |=> $stable(word));

endmodule

// File: rtl/mitopt_core_agg.sv
module mitopt_core_agg #(
    parameter int unsigned NTHR = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NTHR-1:0] dis_i,
    output logic            mitig_on
);
    logic on_d, on_q;

    always_comb begin
        on_d = ~(&dis_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) on_q <= 1'b1;
        else        on_q <= on_d;
    end

    assign mitig_on = on_q;

    p_all_agree_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (&dis_i) |=> !mitig_on);
    p_any_keeps_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(&dis_i) |=> mitig_on);

endmodule

// File: rtl/mitopt_core.sv
module mitopt_core
    import mitopt_pkg::*;
#(
    parameter int unsigned NTHR  = 2,
    parameter int unsigned REG_W = OPT_W,
    localparam int unsigned TIDW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_rng_ctl,
    input  logic             cap_fbclr_ctl,
    input  logic             cap_gds_ctl,
    input  logic             wr_en,
    input  logic [TIDW-1:0]  wr_tid,
    input  logic [REG_W-1:0] wr_data,
    output logic             wr_fault,
    input  logic [TIDW-1:0]  rd_tid,
    output logic [REG_W-1:0] rd_data,
    input  logic             lock_rtm_set,
    input  logic             lock_gds_set,
    input  logic [NTHR-1:0]  in_enclave,
    input  logic [NTHR-1:0]  txn_disable,
    output logic [NTHR-1:0]  rng_mitig_on,
    output logic [NTHR-1:0]  txn_abort_all,
    output logic [NTHR-1:0]  fbclr_skip,
    output logic             gds_mitig_on
);
    logic                        illegal;
    logic [NTHR-1:0]             thr_wr;
    logic [NTHR-1:0]             thr_dis;
    logic [NTHR-1:0][REG_W-1:0]  thr_word;

    mitopt_wr_check #(.REG_W(REG_W)) u_chk (
        .wr_data       (wr_data),
        .cap_rng_ctl   (cap_rng_ctl),
        .cap_fbclr_ctl (cap_fbclr_ctl),
        .cap_gds_ctl   (cap_gds_ctl),
        .illegal       (illegal)
    );

    assign wr_fault = wr_en & illegal;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        assign thr_wr[t] = wr_en & ~illegal & (wr_tid == TIDW'(t));

        mitopt_thread_reg #(.REG_W(REG_W)) u_reg (
            .clk           (clk),
            .rst_n         (rst_n),
            .wr_ok         (thr_wr[t]),
            .wr_data       (wr_data),
            .lock_rtm_set  (lock_rtm_set),
            .lock_gds_set  (lock_gds_set),
            .in_enclave    (in_enclave[t]),
            .txn_disable   (txn_disable[t]),
            .word          (thr_word[t]),
            .gds_dis       (thr_dis[t]),
            .rng_mitig_on  (rng_mitig_on[t]),
            .txn_abort_all (txn_abort_all[t]),
            .fbclr_skip    (fbclr_skip[t])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int t = 0; t < NTHR; t++) begin
            if (rd_tid == TIDW'(t)) rd_data = thr_word[t];
        end
    end

    mitopt_core_agg #(.NTHR(NTHR)) u_agg (
        .clk      (clk),
        .rst_n    (rst_n),
        .dis_i    (thr_dis),
        .mitig_on (gds_mitig_on)
    );

    p_fault_blocks_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fault |-> (thr_wr == '0));
    p_one_thread_written_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(thr_wr));
    p_reserved_faults_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (|wr_data[REG_W-1:RSV_LO])) |-> wr_fault);

endmodule

// File: tb/sim_mitopt_core.sv
module sim_mitopt_core;

    localparam int unsigned PERIOD = 10;
    localparam int unsigned NTHR   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_rng_ctl = 1'b1, cap_fbclr_ctl = 1'b1, cap_gds_ctl = 1'b1;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_tid = '0;
    logic [63:0] wr_data = '0;
    logic        wr_fault;
    logic [0:0]  rd_tid = '0;
    logic [63:0] rd_data;
    logic        lock_rtm_set = 1'b0, lock_gds_set = 1'b0;
    logic [1:0]  in_enclave = '0, txn_disable = '0;
    logic [1:0]  rng_mitig_on, txn_abort_all, fbclr_skip;
    logic        gds_mitig_on;

    int applied = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    mitopt_core #(.NTHR(NTHR)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cap_rng_ctl(cap_rng_ctl), .cap_fbclr_ctl(cap_fbclr_ctl), .cap_gds_ctl(cap_gds_ctl),
        .wr_en(wr_en), .wr_tid(wr_tid), .wr_data(wr_data), .wr_fault(wr_fault),
        .rd_tid(rd_tid), .rd_data(rd_data),
        .lock_rtm_set(lock_rtm_set), .lock_gds_set(lock_gds_set),
        .in_enclave(in_enclave), .txn_disable(txn_disable),
        .rng_mitig_on(rng_mitig_on), .txn_abort_all(txn_abort_all),
        .fbclr_skip(fbclr_skip), .gds_mitig_on(gds_mitig_on)
    );

    typedef struct packed {
        logic        tid;
        logic [2:0]  caps;   // {gds, fbclr, rng}
        logic [63:0] data;
        logic        fault;
        logic [63:0] rd;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 3'b111, 64'h1B, 1'b0, 64'h1B},                  // R2
        '{1'b1, 3'b111, 64'h10, 1'b0, 64'h10},                  // R2
        '{1'b0, 3'b111, 64'h40, 1'b1, 64'h1B},                  // R3
        '{1'b0, 3'b111, 64'h8000_0000_0000_0000, 1'b1, 64'h1B}, // R3
        '{1'b1, 3'b101, 64'h08, 1'b1, 64'h10},                  // R4
        '{1'b1, 3'b110, 64'h01, 1'b1, 64'h10},                  // R4
        '{1'b1, 3'b011, 64'h12, 1'b1, 64'h10},                  // R4
        '{1'b1, 3'b011, 64'h02, 1'b0, 64'h02},                  // R4
        '{1'b0, 3'b111, 64'h24, 1'b0, 64'h00},                  // R2
        '{1'b0, 3'b000, 64'h00, 1'b0, 64'h00},                  // R4
        '{1'b1, 3'b111, 64'h1F, 1'b0, 64'h1B}                   // R2
    };

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        applied++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive at negedge, sample fault before the edge, read back after it
    task automatic do_write(logic tid, logic [63:0] d, logic gds_lk,
                            output logic flt, output logic [63:0] rb);
        @(negedge clk);
        wr_en = 1'b1; wr_tid = tid; wr_data = d; lock_gds_set = gds_lk;
        #1 flt = wr_fault;
        @(negedge clk);
        wr_en = 1'b0; lock_gds_set = 1'b0; rd_tid = tid;
        #1 rb = rd_data;
    endtask

    function automatic logic [63:0] rd_of(logic tid);
        return 64'h0;
    endfunction

    task automatic read_thr(logic tid, output logic [63:0] rb);
        rd_tid = tid;
        #1 rb = rd_data;
    endtask

    initial begin
        logic        f;
        logic [63:0] r;

        #(PERIOD*3) @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        read_thr(1'b0, r); check("R1 rd t0", r, 64'h0);
        read_thr(1'b1, r); check("R1 rd t1", r, 64'h0);
        check("R1 gds_mitig_on", 64'(gds_mitig_on), 64'h1);
        check("R1 wr_fault", 64'(wr_fault), 64'h0);

        for (int i = 0; i < NV; i++) begin
            {cap_gds_ctl, cap_fbclr_ctl, cap_rng_ctl} = VEC[i].caps;
            do_write(VEC[i].tid, VEC[i].data, 1'b0, f, r);
            check($sformatf("vec%0d fault", i), 64'(f), 64'(VEC[i].fault));
            check($sformatf("vec%0d readback", i), r, VEC[i].rd);
        end
        {cap_gds_ctl, cap_fbclr_ctl, cap_rng_ctl} = 3'b111;
        // state: t0 = 0x00, t1 = 0x1B

        // R5
        in_enclave = 2'b00; #1;
        check("R5 t1 outside", 64'(rng_mitig_on[1]), 64'h0);
        check("R5 t0 bit0 clear", 64'(rng_mitig_on[0]), 64'h1);
        in_enclave = 2'b10; #1;
        check("R5 t1 inside", 64'(rng_mitig_on[1]), 64'h1);
        in_enclave = 2'b00;
        // R6
        txn_disable = 2'b00; #1;
        check("R6 t1 allow ctl0", 64'(txn_abort_all[1]), 64'h0);
        check("R6 t0 no allow", 64'(txn_abort_all[0]), 64'h1);
        txn_disable = 2'b10; #1;
        check("R6 t1 allow ctl1", 64'(txn_abort_all[1]), 64'h1);
        txn_disable = 2'b00;
        // R11
        check("R11 t1 skip", 64'(fbclr_skip[1]), 64'h1);
        check("R11 t0 skip", 64'(fbclr_skip[0]), 64'h0);

        // R10: t1 has bit4; write t0 bit4, output moves one clock later
        check("R10 before", 64'(gds_mitig_on), 64'h1);
        do_write(1'b0, 64'h10, 1'b0, f, r);
        check("R10 same cycle still on", 64'(gds_mitig_on), 64'h1);
        @(negedge clk); #1;
        check("R10 all agree off", 64'(gds_mitig_on), 64'h0);

        // R8: lock pulse in the same cycle as a write setting bit4
        do_write(1'b0, 64'h11, 1'b1, f, r);
        check("R8 fault", 64'(f), 64'h0);
        check("R8 t0 lock wins", r, 64'h21);
        read_thr(1'b1, r); check("R8 t1 forced", r, 64'h2B);
        @(negedge clk); #1;
        check("R8 R10 mitig back on", 64'(gds_mitig_on), 64'h1);
        do_write(1'b1, 64'h10, 1'b0, f, r);
        check("R8 write ignored fault", 64'(f), 64'h0);
        check("R8 write ignored rd", r, 64'h20);

        // R7
        do_write(1'b0, 64'h03, 1'b0, f, r);
        check("R7 pre", r, 64'h23);
        @(negedge clk); lock_rtm_set = 1'b1;
        @(negedge clk); lock_rtm_set = 1'b0;
        read_thr(1'b0, r); check("R7 lock clears allow", r, 64'h25);
        do_write(1'b0, 64'h0B, 1'b0, f, r);
        check("R7 fault", 64'(f), 64'h0);
        check("R7 bit1 dropped", r, 64'h2D);
        check("R7 abort all", 64'(txn_abort_all[0]), 64'h1);

        // R9: locks survive writes, reset clears them
        do_write(1'b1, 64'h00, 1'b0, f, r);
        check("R9 t1 locks kept", r, 64'h24);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        read_thr(1'b0, r); check("R9 R1 reset clears t0", r, 64'h0);
        read_thr(1'b1, r); check("R9 R1 reset clears t1", r, 64'h0);
        do_write(1'b1, 64'h12, 1'b0, f, r);
        check("R9 allow writable again", r, 64'h12);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

    initial begin
        #(PERIOD*20000);
        if (!done) begin
            done = 1'b1;
            applied++; bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

endmodule